// File: doc/BRIEF.md
# Smart card byte transmitter with automatic resend

This block sends one byte at a time over a shared, open-drain, single-wire link of the kind used by contact smart cards. Each byte goes out as one frame of ten bit periods: a low start bit, the eight data bits with the least significant bit first, and an even parity bit. A bit period is `CLK_PER_ETU` input clocks, which is 372 by default and is set per instance.

After the parity bit the transmitter lets go of the line for two more bit periods and listens. A receiver that found a parity error pulls the line low during that listening window. If the transmitter sees a low level at its sampling point, it sets an error-signal status flag. With interrupts enabled, that flag raises an error interrupt request. The transmitter then sends the same byte again at once, with no action from software. If the line stays high, the frame is finished: the transmit-empty flag is set, a one-cycle transmit interrupt pulse is given, and a new byte may be written.

Top module: `sc_tx_retry`

## Requirements
- R1: After reset, `line_oe` is 0 (line released), `tx_empty` is 1, and `ers`, `eri` and `txi` are 0. While `tx_empty` is 1 the line stays released.
- R2: A `wr_en` pulse while `tx_empty` is 1 captures `wr_data`. From the next cycle, `tx_empty` is 0 and the start bit is driven: `line_oe` is 1 for `CLK_PER_ETU` cycles.
- R3: Bit period k of the frame (k = 1 to 8) carries data bit k-1. Each period lasts `CLK_PER_ETU` cycles. The line is driven as open drain: a 0 gives `line_oe` = 1 and a 1 gives `line_oe` = 0.
- R4: Bit period 9 carries the parity bit. With the default `ODD_PARITY` = 0, it is the XOR of the eight data bits, so the frame holds an even number of ones.
- R5: During bit periods 10 and 11, which follow the parity bit, `line_oe` is 0.
- R6: `line_in` is sampled on the last clock of bit period 10. If it is 0 there, then at the end of period 11 `ers` becomes 1 and the same byte is sent again from its start bit. `tx_empty` stays 0 throughout.
- R7: `eri` is 1 exactly when `ers` is 1 and `rie` is 1.
- R8: If `line_in` was 1 at the sampling point, then at the end of period 11 `tx_empty` becomes 1 and `txi` is 1 for exactly one cycle.
- R9: A `wr_en` pulse while `tx_empty` is 0 is ignored. The frame in progress and any resend keep the original byte.
- R10: An `ers_clr` pulse clears `ers` on the next cycle. If a new error is detected in the same cycle as the clear, the set wins and `ers` stays 1.
- R11: A low level on `line_in` at any clock other than the sampling point of R6 has no effect on the frame, on `ers` or on completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit period is CLK_PER_ETU cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | DATA_W | Byte to transmit |
| rie | input | 1 | Enable for the error interrupt request |
| ers_clr | input | 1 | Software clear of the error-signal status flag |
| line_in | input | 1 | Level observed on the shared line |
| line_oe | output | 1 | 1 pulls the line low, 0 releases it |
| tx_empty | output | 1 | Ready for a new byte |
| txi | output | 1 | One-cycle pulse when a frame completes cleanly |
| ers | output | 1 | Error-signal status flag |
| eri | output | 1 | Error interrupt request |

## Verification
Two events can fall on the same clock: software clearing the error-signal flag, and the transmitter setting that flag at the end of a frame that drew an error. The bench provokes this by leaving the flag set after one errored frame, sending a second errored frame, and pulsing the clear on exactly the last clock of that frame's listening window. It then expects the flag to remain set, and afterwards checks that a clear with no competing set does take effect. All 256 byte values are also swept on a small bit period, and every cycle of the line output is compared with the level computed from the byte and its parity.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SEND = 1'b1
   } tx_state_t;

   // bit periods held released after the parity bit (listen window)
   localparam int unsigned LISTEN_ETUS = 2;
endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
   parameter int unsigned CLK_PER_ETU = 372
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic etu_last
);
   localparam int unsigned CW = (CLK_PER_ETU > 1) ? $clog2(CLK_PER_ETU) : 1;

   logic [CW-1:0] cnt;

   assign etu_last = run && (cnt == CW'(CLK_PER_ETU - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || etu_last) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sc_frame_src.sv
module sc_frame_src #(
   parameter int unsigned DATA_W     = 8,
   parameter bit          ODD_PARITY = 1'b0,
   parameter int unsigned IDX_W      = 4
) (
   input  logic [DATA_W-1:0] data,
   input  logic [IDX_W-1:0]  idx,
   output logic              drive_low
);
   logic par;
   logic lvl;

   generate
      if (ODD_PARITY) begin : g_odd
         assign par = ~^data;
      end else begin : g_even
         assign par = ^data;
      end
   endgenerate

   always_comb begin
      lvl = 1'b1;
      if (idx == '0) begin
         lvl = 1'b0;
      end
      for (int k = 0; k < DATA_W; k++) begin
         if (idx == IDX_W'(k + 1)) begin
            lvl = data[k];
         end
      end
      if (idx == IDX_W'(DATA_W + 1)) begin
         lvl = par;
      end
   end

   assign drive_low = ~lvl;
endmodule

// File: rtl/sc_tx_retry.sv
module sc_tx_retry #(
   parameter int unsigned CLK_PER_ETU = 372,
   parameter int unsigned DATA_W      = 8,
   parameter bit          ODD_PARITY  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rie,
   input  logic              ers_clr,
   input  logic              line_in,
   output logic              line_oe,
   output logic              tx_empty,
   output logic              txi,
   output logic              ers,
   output logic              eri
);
   import sc_tx_pkg::*;

   localparam int unsigned FRAME_ETUS = DATA_W + 2;
   localparam int unsigned TOTAL_ETUS = FRAME_ETUS + LISTEN_ETUS;
   localparam int unsigned IDX_W      = $clog2(TOTAL_ETUS);

   if (CLK_PER_ETU < 4) begin : g_bad_etu
      $error("CLK_PER_ETU must be at least 4");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end

   tx_state_t         state;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] data_q;
   logic              err_q;
   logic              etu_last;
   logic              drive_low;
   logic              load;
   logic              sample_pt;
   logic              frame_end;
   logic              sending;

   assign sending   = (state == ST_SEND);
   assign load      = wr_en && (state == ST_IDLE);
   assign sample_pt = etu_last && (idx == IDX_W'(FRAME_ETUS));
   assign frame_end = etu_last && (idx == IDX_W'(TOTAL_ETUS - 1));

   sc_etu_timer #(
      .CLK_PER_ETU (CLK_PER_ETU)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (sending),
      .etu_last (etu_last)
   );

   sc_frame_src #(
      .DATA_W     (DATA_W),
      .ODD_PARITY (ODD_PARITY),
      .IDX_W      (IDX_W)
   ) i_src (
      .data      (data_q),
      .idx       (idx),
      .drive_low (drive_low)
   );

   assign line_oe = sending && drive_low;
   assign eri     = ers && rie;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         idx      <= '0;
         data_q   <= '0;
         err_q    <= 1'b0;
         tx_empty <= 1'b1;
         txi      <= 1'b0;
         ers      <= 1'b0;
      end else begin
         txi <= frame_end && !err_q;

         if (load) begin
            data_q   <= wr_data;
            state    <= ST_SEND;
            idx      <= '0;
            tx_empty <= 1'b0;
         end else if (etu_last) begin
            if (frame_end) begin
               idx <= '0;
               if (!err_q) begin
                  state    <= ST_IDLE;
                  tx_empty <= 1'b1;
               end
            end else begin
               idx <= idx + 1'b1;
            end
         end

         if (sample_pt) begin
            err_q <= !line_in;
         end

         if (frame_end && err_q) begin
            ers <= 1'b1;
         end else if (ers_clr) begin
            ers <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sc_tx_retry_chk.sv
module sc_tx_retry_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rie,
   input logic              ers_clr,
   input logic              line_oe,
   input logic              tx_empty,
   input logic              txi,
   input logic              ers,
   input logic              eri,
   input logic              frame_end,
   input logic              err_q,
   input logic [DATA_W-1:0] data_q
);
   p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> !line_oe);

   p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty && wr_en) |=> (!tx_empty && line_oe));

   p_ers_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ers) |-> $past(frame_end && err_q));

   p_eri_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      eri |-> (ers && rie));

   p_txi_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      txi |-> (tx_empty && $past(!tx_empty)));

   p_txi_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      txi |=> !txi);

   p_busy_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_empty && wr_en) |=> $stable(data_q));

   p_ers_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ers_clr && !(frame_end && err_q)) |=> !ers);
endmodule

bind sc_tx_retry sc_tx_retry_chk #(
   .DATA_W (DATA_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .rie       (rie),
   .ers_clr   (ers_clr),
   .line_oe   (line_oe),
   .tx_empty  (tx_empty),
   .txi       (txi),
   .ers       (ers),
   .eri       (eri),
   .frame_end (frame_end),
   .err_q     (err_q),
   .data_q    (data_q)
);

// File: tb/test_sc_tx_retry.sv
module test_sc_tx_retry;
   localparam int PERIOD = 10;
   localparam int N      = 4;
   localparam int FRAMEC = 12 * N;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rie = 1'b0;
   logic       ers_clr = 1'b0;
   logic       ext_low = 1'b0;
   logic       line_in;
   logic       line_oe, tx_empty, txi, ers, eri;

   int n_chk = 0;
   int n_fail = 0;

   always #(PERIOD / 2) clk = ~clk;

   assign line_in = ~(line_oe | ext_low);

   sc_tx_retry #(.CLK_PER_ETU(N)) i_sc_tx_retry (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rie(rie), .ers_clr(ers_clr), .line_in(line_in),
      .line_oe(line_oe), .tx_empty(tx_empty), .txi(txi),
      .ers(ers), .eri(eri));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic exp_oe(input logic [7:0] d, input int k);
      if (k == 0) return 1'b1;
      if (k <= 8) return ~d[k-1];
      if (k == 9) return ~(^d);
      return 1'b0;
   endfunction

   task automatic load(input logic [7:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(posedge clk);
   endtask

   // assumes the frame started on the preceding posedge
   task automatic frame_body(input logic [7:0] d, input bit err,
                             input bit busy_wr, input bit clr_end);
      for (int j = 0; j < FRAMEC; j++) begin
         int k;
         k = j / N;
         @(negedge clk);
         wr_en = 1'b0;
         if (busy_wr && j == 5) begin
            wr_en   = 1'b1;
            wr_data = ~d;
         end
         ers_clr = clr_end && (j == FRAMEC - 1);
         if (err) ext_low = (k == 10);
         else     ext_low = (k == 11) || (k == 10 && (j % N) == 0);
         if (k == 0) chk("R2 start bit", int'(line_oe), 1);
         else if (k <= 8) chk("R3 data bit", int'(line_oe), int'(exp_oe(d, k)));
         else if (k == 9) chk("R4 parity bit", int'(line_oe), int'(exp_oe(d, k)));
         else chk("R5 listen window released", int'(line_oe), 0);
         if (j == 1) chk("R2 tx_empty low while sending", int'(tx_empty), 0);
      end
      @(posedge clk);
      #1;
      ext_low = 1'b0;
      ers_clr = 1'b0;
      wr_en   = 1'b0;
   endtask

   task automatic post(input bit err);
      if (err) begin
         chk("R6 ers set on error signal", int'(ers), 1);
         chk("R6 resend starts", int'(line_oe), 1);
         chk("R6 tx_empty stays low", int'(tx_empty), 0);
         chk("R7 eri follows ers and rie", int'(eri), int'(rie));
      end else begin
         chk("R8 tx_empty after clean frame", int'(tx_empty), 1);
         chk("R8 txi pulse", int'(txi), 1);
         chk("R11 line released at idle", int'(line_oe), 0);
         @(posedge clk);
         #1;
         chk("R8 txi one cycle", int'(txi), 0);
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] errset [4];
      errset[0] = 8'h00; errset[1] = 8'hA5; errset[2] = 8'hFF; errset[3] = 8'h3C;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 line released", int'(line_oe), 0);
      chk("R1 tx_empty", int'(tx_empty), 1);
      chk("R1 ers", int'(ers), 0);
      chk("R1 eri", int'(eri), 0);
      chk("R1 txi", int'(txi), 0);

      // full sweep of byte values, clean frames, busy writes on some
      for (int b = 0; b < 256; b++) begin
         rie = b[0];
         load(8'(b));
         frame_body(8'(b), 1'b0, (b % 17) == 0, 1'b0);
         post(1'b0);
         chk("R11 no error flag from off-sample lows", int'(ers), 0);
         chk("R9 R7 eri low", int'(eri), 0);
      end

      // error-signal frames, resend, coincident set and clear
      for (int e = 0; e < 4; e++) begin
         rie = e[0];
         load(errset[e]);
         frame_body(errset[e], 1'b1, e == 2, 1'b0);
         post(1'b1);
         frame_body(errset[e], 1'b1, 1'b0, 1'b1);
         post(1'b1);
         chk("R10 set wins over clear", int'(ers), 1);
         frame_body(errset[e], 1'b0, 1'b0, 1'b0);
         post(1'b0);
         chk("R8 ers kept until cleared", int'(ers), 1);
         rie = 1'b1;
         #1;
         chk("R7 eri with rie on", int'(eri), 1);
         @(negedge clk);
         ers_clr = 1'b1;
         @(posedge clk);
         #1;
         ers_clr = 1'b0;
         chk("R10 clear alone", int'(ers), 0);
         chk("R7 eri cleared", int'(eri), 0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule